// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block makes the serial bit clock and two frame clocks, one for transmit and one for receive, that a digital audio serial port needs. All three come from a single master audio clock through integer dividers. Every divide ratio sits in one 32-bit clock control word, which a write strobe loads in one cycle. The bit divider counts master clock cycles. Each frame divider counts bit clock periods, so the transmit and receive sides can use different frame lengths.

A single control bit selects the mode. In master mode the block drives the clocks it generates. In slave mode it forwards the externally supplied bit and frame clocks and holds its own counters at zero. A second control bit inverts the bit clock, so that samples can be launched on either edge.

A typical setup runs the master clock at 256 times the sample rate and uses two 32-bit slots per frame. That gives a bit divide ratio of 4 and a frame length of 64 bit clocks, and this is the reset configuration.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the control word is 0x00033F3F: master mode, no inversion, bit ratio 4, and 64 bit clocks per frame on both sides. All outputs start low.
- R2: The bit ratio is N = bits[23:16] + 1. For N of 2 or more, the bit clock has a period of N master cycles. It is low for the first floor(N/2) cycles of each period and high for the rest.
- R3: When bits[23:16] = 0 (N = 1), the bit clock output equals the master clock.
- R4: The transmit frame length is F = bits[7:0] + 1 bit clocks. The frame counter advances on each falling edge of the uninverted bit clock. The transmit frame clock is low for the first floor(F/2) bit periods of each frame and high for the rest, so with F = 1 it stays high.
- R5: The receive frame clock follows the rule of R4 with F = bits[15:8] + 1, independently of the transmit side.
- R6: Bit 26 = 1 inverts the bit clock output in both master and slave mode. The frame clocks are not affected.
- R7: Bit 27 = 1 selects slave mode. The bit clock and both frame clocks then follow the external clock inputs, with the inversion of R6 applied to the bit clock. In master mode the external inputs have no effect.
- R8: A write restarts all counters. In the cycle after the write, the bit clock is at the start of its low phase and both frames are at count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word value to load |
| ext_sclk_i | input | 1 | External bit clock, used in slave mode |
| ext_tx_fs_i | input | 1 | External transmit frame clock, used in slave mode |
| ext_rx_fs_i | input | 1 | External receive frame clock, used in slave mode |
| sclk_o | output | 1 | Bit clock |
| tx_fs_o | output | 1 | Transmit frame clock |
| rx_fs_o | output | 1 | Receive frame clock |

## Verification
The bench checks several ratio cases:
- An odd bit ratio. A design that rounds the half period the wrong way would move the rising edge by one master cycle.
- A ratio of one, which must forward the master clock. A plain counter would stall at a constant level there.
- A frame length of one, which must hold the frame clock high.
- Transmit and receive frame lengths that differ. A design that shared one frame counter would produce the same frame clock on both sides.

Every configuration is written while the block is running, so a design that kept old counts across a write would start mid-period. The slave-mode tests toggle the external pins with the inversion both on and off. Master-mode runs hold those pins high, so any leak from them into the outputs shows up.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  localparam int unsigned CFG_W    = 32;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned MODE_POS = 27;
  localparam int unsigned INV_POS  = 26;
  localparam int unsigned BDIV_LSB = 16;
  localparam int unsigned RXF_LSB  = 8;
  localparam int unsigned TXF_LSB  = 0;

  typedef struct packed {
    logic               slave;
    logic               inv;
    logic [FIELD_W-1:0] bdiv_m1;
    logic [FIELD_W-1:0] rxf_m1;
    logic [FIELD_W-1:0] txf_m1;
  } clk_cfg_t;

  function automatic clk_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    clk_cfg_t c;
    c.slave   = w[MODE_POS];
    c.inv     = w[INV_POS];
    c.bdiv_m1 = w[BDIV_LSB +: FIELD_W];
    c.rxf_m1  = w[RXF_LSB +: FIELD_W];
    c.txf_m1  = w[TXF_LSB +: FIELD_W];
    return c;
  endfunction

endpackage

// File: rtl/audclk_cfg_reg.sv
module audclk_cfg_reg
  import audclk_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_WORD = 32'h0003_3F3F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output clk_cfg_t         cfg_o
);

  localparam clk_cfg_t RST_CFG = unpack_cfg(RST_WORD);

  clk_cfg_t cfg_q, cfg_d;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata_i[CFG_W-1:MODE_POS+1], wdata_i[INV_POS-1:BDIV_LSB+FIELD_W]};

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d = unpack_cfg(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_CFG;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/audclk_divctr.sv
module audclk_divctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] ratio_m1_i,
  output logic             level_o,
  output logic             wrap_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] half;
  logic             at_end;

  assign at_end = (cnt_q == ratio_m1_i);
  assign half   = ({1'b0, ratio_m1_i} + EXT_W'(1)) >> 1;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      if (at_end) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap_o  = adv_i && !hold_i && at_end;
  assign level_o = ({1'b0, cnt_q} >= half);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audclk_pkg::*;
#(
  parameter logic [31:0] RST_WORD = 32'h0003_3F3F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        ext_sclk_i,
  input  logic        ext_tx_fs_i,
  input  logic        ext_rx_fs_i,
  output logic        sclk_o,
  output logic        tx_fs_o,
  output logic        rx_fs_o
);

  localparam int unsigned NFRM = 2;

  clk_cfg_t           cfg_q;
  logic               cfg_slave;
  logic               cfg_inv;
  logic [FIELD_W-1:0] cfg_bdiv_m1;
  logic               hold;
  logic               bit_level;
  logic               bit_wrap;
  logic               bit_int;
  logic [FIELD_W-1:0] frm_ratio [NFRM];
  logic [NFRM-1:0]    frm_level;
  logic [NFRM-1:0]    frm_wrap;
  logic               unused_frm_wrap;

  audclk_cfg_reg #(.RST_WORD(RST_WORD)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q)
  );

  assign cfg_slave   = cfg_q.slave;
  assign cfg_inv     = cfg_q.inv;
  assign cfg_bdiv_m1 = cfg_q.bdiv_m1;
  assign hold        = cfg_q.slave || cfg_we_i;

  audclk_divctr #(.CNT_W(FIELD_W)) u_bitdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold),
    .adv_i      (1'b1),
    .ratio_m1_i (cfg_q.bdiv_m1),
    .level_o    (bit_level),
    .wrap_o     (bit_wrap)
  );

  // index 0: transmit frame, index 1: receive frame
  assign frm_ratio[0] = cfg_q.txf_m1;
  assign frm_ratio[1] = cfg_q.rxf_m1;

  for (genvar g = 0; g < NFRM; g++) begin : g_frm
    audclk_divctr #(.CNT_W(FIELD_W)) u_frmdiv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hold_i     (hold),
      .adv_i      (bit_wrap),
      .ratio_m1_i (frm_ratio[g]),
      .level_o    (frm_level[g]),
      .wrap_o     (frm_wrap[g])
    );
  end

  assign unused_frm_wrap = ^frm_wrap;

  // ratio of one forwards the master clock itself
  assign bit_int = (cfg_q.bdiv_m1 == '0) ? clk_i : bit_level;

  assign sclk_o  = (cfg_q.slave ? ext_sclk_i : bit_int) ^ cfg_q.inv;
  assign tx_fs_o = cfg_q.slave ? ext_tx_fs_i : frm_level[0];
  assign rx_fs_o = cfg_q.slave ? ext_rx_fs_i : frm_level[1];

endmodule

// File: rtl/audclk_chk.sv
module audclk_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_wdata_i,
  input logic        ext_sclk_i,
  input logic        ext_tx_fs_i,
  input logic        ext_rx_fs_i,
  input logic        sclk_o,
  input logic        tx_fs_o,
  input logic        rx_fs_o,
  input logic        cfg_slave,
  input logic        cfg_inv,
  input logic [7:0]  cfg_bdiv_m1
);

  // R8: a master-mode write with ratio >= 2 restarts the bit clock in its low phase
  p_restart_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_wdata_i[27] && cfg_wdata_i[23:16] != 8'd0)
      |=> (sclk_o == $past(cfg_wdata_i[26])));

  // R4: the transmit frame clock only moves together with a bit clock edge
  p_tx_on_bit_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_slave && !$past(cfg_slave) && !$past(cfg_we_i) && cfg_bdiv_m1 != 8'd0
      && tx_fs_o != $past(tx_fs_o)) |-> (sclk_o != $past(sclk_o)));

  // R5: the receive frame clock only moves together with a bit clock edge
  p_rx_on_bit_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_slave && !$past(cfg_slave) && !$past(cfg_we_i) && cfg_bdiv_m1 != 8'd0
      && rx_fs_o != $past(rx_fs_o)) |-> (sclk_o != $past(sclk_o)));

  // R7: slave mode forwards the external frame clocks
  p_slave_fs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_slave |-> (tx_fs_o == ext_tx_fs_i && rx_fs_o == ext_rx_fs_i));

  // R6: slave mode forwards the external bit clock with the polarity control applied
  p_slave_sclk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_slave |-> (sclk_o == (ext_sclk_i ^ cfg_inv)));

endmodule

bind audio_clkgen audclk_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .ext_sclk_i  (ext_sclk_i),
  .ext_tx_fs_i (ext_tx_fs_i),
  .ext_rx_fs_i (ext_rx_fs_i),
  .sclk_o      (sclk_o),
  .tx_fs_o     (tx_fs_o),
  .rx_fs_o     (rx_fs_o),
  .cfg_slave   (cfg_slave),
  .cfg_inv     (cfg_inv),
  .cfg_bdiv_m1 (cfg_bdiv_m1)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;

  logic        clk;
  logic        rst_n;
  logic        we;
  logic [31:0] wdata;
  logic        e_sclk, e_tx, e_rx;
  logic        sclk, tx_fs, rx_fs;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] RST_WORD = 32'h0003_3F3F;
  localparam int NVEC = 5;
  localparam logic [31:0] VCFG [NVEC] = '{
    32'h0003_0707,   // N=4, F=8/8
    32'h0002_0305,   // N=3 odd, rx F=4, tx F=6
    32'h0000_0302,   // N=1 pass-through, rx F=4, tx F=3
    32'h0401_0100,   // inverted, N=2, rx F=2, tx F=1
    32'h0007_0F0F    // N=8, F=16
  };
  localparam int VLEN [NVEC] = '{80, 80, 30, 20, 300};

  audio_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .ext_sclk_i(e_sclk), .ext_tx_fs_i(e_tx), .ext_rx_fs_i(e_rx),
    .sclk_o(sclk), .tx_fs_o(tx_fs), .rx_fs_o(rx_fs)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Expected outputs m rising edges after the counters were zeroed, sampled with clk low
  task automatic model(input logic [31:0] w, input int m,
                       output logic s, output logic t, output logic r);
    int n, ft, fr, fb;
    n  = int'(w[23:16]) + 1;
    fr = int'(w[15:8]) + 1;
    ft = int'(w[7:0]) + 1;
    if (n == 1) begin
      s  = 1'b0;
      fb = m;
    end else begin
      s  = ((m % n) >= (n / 2));
      fb = m / n;
    end
    s = s ^ w[26];
    t = ((fb % ft) >= (ft / 2));
    r = ((fb % fr) >= (fr / 2));
  endtask

  task automatic run_model(input logic [31:0] w, input int len, input string stag);
    logic es, et, er;
    for (int m = 0; m < len; m++) begin
      model(w, m, es, et, er);
      check((m == 0) ? "R8" : stag, sclk, es);
      check((m == 0) ? "R8" : "R4", tx_fs, et);
      check((m == 0) ? "R8" : "R5", rx_fs, er);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1;
    wdata = w;
    @(negedge clk);
    we = 1'b0;
    wdata = 32'h0;
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; wdata = 32'h0;
    e_sclk = 1'b1; e_tx = 1'b1; e_rx = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    check("R1", sclk, 1'b0);
    check("R1", tx_fs, 1'b0);
    check("R1", rx_fs, 1'b0);
    rst_n = 1'b1;
    // R1: reset configuration runs ratio 4, 64-bit frames
    begin
      logic es, et, er;
      for (int m = 0; m < 300; m++) begin
        model(RST_WORD, m, es, et, er);
        check("R1", sclk, es);
        check("R1", tx_fs, et);
        check("R1", rx_fs, er);
        @(negedge clk);
      end
    end

    // Table walk: each write lands while the block is running (R8)
    for (int v = 0; v < NVEC; v++) begin
      string stag;
      write_cfg(VCFG[v]);
      if (VCFG[v][23:16] == 8'd0) stag = "R3";
      else if (VCFG[v][26]) stag = "R6";
      else stag = "R2";
      run_model(VCFG[v], VLEN[v], stag);
    end

    // R7: slave mode forwards external clocks, no inversion
    write_cfg(32'h0800_0000);
    for (int k = 0; k < 8; k++) begin
      e_sclk = k[0]; e_tx = k[1]; e_rx = k[2];
      #1;
      check("R7", sclk, k[0]);
      check("R7", tx_fs, k[1]);
      check("R7", rx_fs, k[2]);
      @(negedge clk);
    end
    // R6: inversion in slave mode touches only the bit clock
    write_cfg(32'h0C00_0000);
    for (int k = 0; k < 8; k++) begin
      e_sclk = k[0]; e_tx = k[1]; e_rx = k[2];
      #1;
      check("R6", sclk, ~k[0]);
      check("R6", tx_fs, k[1]);
      check("R6", rx_fs, k[2]);
      @(negedge clk);
    end
    // R8: back to master, counters start from zero; external pins held high are ignored (R7)
    e_sclk = 1'b1; e_tx = 1'b1; e_rx = 1'b1;
    write_cfg(32'h0003_0303);
    run_model(32'h0003_0303, 40, "R7");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule